// File: doc/BRIEF.md
# DMA Channel Enable Command Registers

This block is the register front end for a 64-channel DMA controller. It holds two 64-bit vectors: a request-enable vector, which goes straight to the transfer engine, and an error-interrupt-enable vector. Each vector is seen on the bus as a high and a low 32-bit word. Request-enable bits are never written directly. Software instead writes byte-wide "set" commands to a command word. Each command byte names one channel, or asks for all channels, or is a no-op. Because of the no-op flag, one 32-bit write can pack up to four independent commands, one per byte lane.

The block also merges the per-channel error flags from the engine with the error-interrupt-enable vector. From these it drives one interrupt request per channel and one combined request. The bus is a plain single-cycle write port and a read port with byte strobes. Read data is registered and appears one cycle after the read strobe.

The block has no sequencing of its own. The only state is the two enable vectors and the read-data register. There are no named states or transitions: each write takes effect at the clock edge that samples it, and the merged interrupts are combinational.

Top module: `dma_enable_regs`

## Requirements
- R1: After reset, both enable vectors, `req_enable`, `rdata`, `err_irq` and `err_irq_any` are all zero, whatever `err_flags` carries.
- R2: A strobed command byte with bit 7 = 0 and bit 6 = 0 sets only request-enable bit `byte[5:0]` at the next clock edge.
- R3: A strobed command byte with bit 7 = 0 and bit 6 = 1 (values 64..127) sets every request-enable bit; bits 5..0 are don't-care.
- R4: A command byte with bit 7 = 1 changes nothing, whatever its lower bits hold.
- R5: The command word is at offset 0x18. Byte lane k is `wdata[8k+7:8k]`, gated by `wstrb[k]`. All strobed lanes of one write act in the same cycle, and unstrobed lanes are ignored.
- R6: A read of the command word (0x18) returns zero.
- R7: The error-interrupt-enable vector is read/write per byte lane. Offset 0x10 holds channels 63..32 (bit n-32 = channel n), and offset 0x14 holds channels 31..0.
- R8: `err_irq[n]` is 1 exactly when `err_flags[n]` is 1 and the channel's error-interrupt-enable bit is 1. This holds in the same cycle.
- R9: `err_irq_any` is 1 exactly when at least one bit of `err_irq` is 1.
- R10: The request-enable vector reads at 0x08 (channels 63..32) and 0x0C (channels 31..0). Read data appears on `rdata` in the cycle after `rd_en`, and unmapped offsets read zero.
- R11: Command writes only ever set request-enable bits; no bit of `req_enable` ever goes from 1 to 0 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the 32-bit word |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane write enables |
| rdata | output | 32 | Registered read data |
| err_flags | input | 64 | Per-channel error flags from the engine |
| req_enable | output | 64 | Request-enable vector |
| err_irq | output | 64 | Per-channel error interrupt requests |
| err_irq_any | output | 1 | OR of all per-channel error interrupts |

## Verification
The checker watches several rules on every cycle:
- request-enable bits never drop (R11);
- a command write with all strobed lanes flagged no-op leaves the vector stable (R4);
- a strobed global-set byte fills the vector (R3);
- a read of the command word yields zero (R6);
- the per-channel and combined interrupts agree with the flags and enables (R8, R9).

Some behaviours only the bench scenarios can show. These are the exact bit a channel index selects, and how lanes combine when one write mixes valid, no-op and unstrobed bytes. They also include the word and bit placement of both vectors behind their offsets and byte-masked writes to the interrupt-enable words. The bench compares each of these against its own model through reads.

// File: rtl/dma_enable_pkg.sv
package dma_enable_pkg;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int NUM_CH   = 2 * WORD_W;
    localparam int IDX_W    = $clog2(NUM_CH);

    localparam logic [7:0] OFF_REQ_HI = 8'h08;
    localparam logic [7:0] OFF_REQ_LO = 8'h0C;
    localparam logic [7:0] OFF_EEI_HI = 8'h10;
    localparam logic [7:0] OFF_EEI_LO = 8'h14;
    localparam logic [7:0] OFF_CMD    = 8'h18;

    typedef struct packed {
        logic             skip;
        logic             all;
        logic [IDX_W-1:0] idx;
    } set_cmd_t;

    function automatic set_cmd_t split_cmd(input logic [7:0] b);
        set_cmd_t c;
        c.skip = b[7];
        c.all  = b[6];
        c.idx  = b[IDX_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/set_cmd_lane.sv
module set_cmd_lane
    import dma_enable_pkg::*;
(
    input  logic              lane_en,
    input  logic [7:0]        cmd_byte,
    output logic [NUM_CH-1:0] set_mask
);
    set_cmd_t cmd;

    always_comb begin
        cmd      = split_cmd(cmd_byte);
        set_mask = '0;
        if (lane_en && !cmd.skip) begin
            if (cmd.all)
                set_mask = '1;
            else
                set_mask[cmd.idx] = 1'b1;
        end
    end
endmodule

// File: rtl/req_enable_vec.sv
module req_enable_vec
    import dma_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_mask,
    output logic [NUM_CH-1:0] vec_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else
            vec_q <= vec_q | set_mask;
    end
endmodule

// File: rtl/irq_enable_vec.sv
module irq_enable_vec
    import dma_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  wstrb,
    output logic [NUM_CH-1:0] vec_q
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[WORD_W+8*k +: 8] <= '0;
                vec_q[8*k +: 8]        <= '0;
            end else begin
                if (we_hi && wstrb[k])
                    vec_q[WORD_W+8*k +: 8] <= wdata[8*k +: 8];
                if (we_lo && wstrb[k])
                    vec_q[8*k +: 8] <= wdata[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/err_irq_merge.sv
module err_irq_merge
    import dma_enable_pkg::*;
(
    input  logic [NUM_CH-1:0] flags,
    input  logic [NUM_CH-1:0] enables,
    output logic [NUM_CH-1:0] irq,
    output logic              irq_any
);
    always_comb begin
        irq     = flags & enables;
        irq_any = |irq;
    end
endmodule

// File: rtl/dma_enable_regs.sv
module dma_enable_regs
    import dma_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    output logic [31:0]       rdata,
    input  logic [63:0]       err_flags,
    output logic [63:0]       req_enable,
    output logic [63:0]       err_irq,
    output logic              err_irq_any
);
    logic              cmd_hit;
    logic [NUM_CH-1:0] lane_mask [LANES];
    logic [NUM_CH-1:0] set_all_lanes;
    logic [NUM_CH-1:0] eei_q;
    logic [WORD_W-1:0] rd_next;

    assign cmd_hit = wr_en && (addr == OFF_CMD);

    for (genvar k = 0; k < LANES; k++) begin : g_cmd
        set_cmd_lane u_lane (
            .lane_en  (cmd_hit && wstrb[k]),
            .cmd_byte (wdata[8*k +: 8]),
            .set_mask (lane_mask[k])
        );
    end

    always_comb begin
        set_all_lanes = '0;
        for (int k = 0; k < LANES; k++)
            set_all_lanes = set_all_lanes | lane_mask[k];
    end

    req_enable_vec u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_all_lanes),
        .vec_q    (req_enable)
    );

    irq_enable_vec u_eei (
        .clk   (clk),
        .rst_n (rst_n),
        .we_hi (wr_en && (addr == OFF_EEI_HI)),
        .we_lo (wr_en && (addr == OFF_EEI_LO)),
        .wdata (wdata),
        .wstrb (wstrb),
        .vec_q (eei_q)
    );

    err_irq_merge u_irq (
        .flags   (err_flags),
        .enables (eei_q),
        .irq     (err_irq),
        .irq_any (err_irq_any)
    );

    always_comb begin
        unique case (addr)
            OFF_REQ_HI: rd_next = req_enable[NUM_CH-1:WORD_W];
            OFF_REQ_LO: rd_next = req_enable[WORD_W-1:0];
            OFF_EEI_HI: rd_next = eei_q[NUM_CH-1:WORD_W];
            OFF_EEI_LO: rd_next = eei_q[WORD_W-1:0];
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end
endmodule

// File: rtl/dma_enable_regs_chk.sv
module dma_enable_regs_chk
    import dma_enable_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  addr,
    input logic [31:0] wdata,
    input logic [3:0]  wstrb,
    input logic [31:0] rdata,
    input logic [63:0] err_flags,
    input logic [63:0] req_enable,
    input logic [63:0] err_irq,
    input logic        err_irq_any,
    input logic [63:0] eei_q
);
    logic cmd_wr, any_global, all_skip;

    always_comb begin
        cmd_wr     = wr_en && (addr == OFF_CMD);
        any_global = 1'b0;
        all_skip   = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (wstrb[k] && !wdata[8*k+7]) begin
                all_skip = 1'b0;
                if (wdata[8*k+6])
                    any_global = 1'b1;
            end
        end
    end

    // R11
    req_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_enable) & ~req_enable) == 64'd0));

    // R4
    noop_cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && all_skip) |=> $stable(req_enable));

    // R3
    global_set_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && any_global) |=> (&req_enable));

    // R6
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_CMD) |=> (rdata == 32'd0));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq & ~(err_flags & eei_q)) == 64'd0 && (err_irq | ~(err_flags & eei_q)) == '1);

    // R9
    irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_any == ($countones(err_irq) != 0));
endmodule

bind dma_enable_regs dma_enable_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .wstrb      (wstrb),
    .rdata      (rdata),
    .err_flags  (err_flags),
    .req_enable (req_enable),
    .err_irq    (err_irq),
    .err_irq_any(err_irq_any),
    .eei_q      (eei_q)
);

// File: tb/test_dma_enable_regs.sv
`timescale 1ns/1ps
module test_dma_enable_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic [31:0] rdata;
    logic [63:0] err_flags = '0;
    logic [63:0] req_enable, err_irq;
    logic        err_irq_any;

    int checks = 0, errors = 0;
    logic [63:0] m_req = '0, m_eei = '0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    dma_enable_regs i_dma_enable_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .err_flags(err_flags),
        .req_enable(req_enable), .err_irq(err_irq), .err_irq_any(err_irq_any)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d; wstrb = s;
        if (a == 8'h18) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b;
                b = d[8*k +: 8];
                if (s[k] && !b[7]) begin
                    if (b[6]) m_req = '1;
                    else      m_req[b[5:0]] = 1'b1;
                end
            end
        end else if (a == 8'h10 || a == 8'h14) begin
            for (int k = 0; k < 4; k++)
                if (s[k]) m_eei[(a == 8'h10 ? 32 : 0) + 8*k +: 8] = d[8*k +: 8];
        end
        @(negedge clk);
        wr_en = 0; wstrb = '0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 0;
    endtask

    // monitor: read captured at posedge, compared at following negedge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                check(tag_q.pop_front(), {32'd0, rdata}, {32'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        err_flags = '1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 req_enable", req_enable, 64'd0);
        check("R1 rdata", {32'd0, rdata}, 64'd0);
        check("R1 err_irq", err_irq, 64'd0);
        check("R1 err_irq_any", {63'd0, err_irq_any}, 64'd0);
        rst_n = 1;
        err_flags = '0;
        do_read(8'h08, 32'd0, "R1 R10 req hi reset");
        do_read(8'h10, 32'd0, "R1 R7 eei hi reset");

        // R2 single channel
        do_write(8'h18, 32'h0000_0005, 4'b0001);
        do_read(8'h0C, m_req[31:0], "R2 ch5 low word");
        do_write(8'h18, 32'h0000_2500, 4'b0010);
        do_read(8'h08, m_req[63:32], "R2 ch37 high word");
        check("R2 req_enable port", req_enable, m_req);

        // R4 + R5 mixed lanes: noop, ch3, noop, ch63
        do_write(8'h18, 32'h3F8F_0385, 4'b1111);
        do_read(8'h0C, m_req[31:0], "R5 R4 packed low");
        do_read(8'h08, m_req[63:32], "R5 R4 packed high");
        // R5 unstrobed lane ignored
        do_write(8'h18, 32'h0000_070A, 4'b0010);
        do_read(8'h0C, m_req[31:0], "R5 unstrobed lane");
        // R4 noop with global bit
        do_write(8'h18, 32'hC0C0_C0C0, 4'b1111);
        check("R4 noop global ignored", req_enable, m_req);

        // R6 command read
        do_read(8'h18, 32'd0, "R6 cmd read zero");
        // R10 unmapped
        do_read(8'h00, 32'd0, "R10 unmapped read");

        // R7 eei byte writes
        do_write(8'h10, 32'hA5A5_1234, 4'b1100);
        do_write(8'h14, 32'h0000_F00F, 4'b0011);
        do_read(8'h10, m_eei[63:32], "R7 eei hi");
        do_read(8'h14, m_eei[31:0], "R7 eei lo");

        // R8 / R9
        @(negedge clk);
        err_flags = 64'hFFFF_0000_0000_FFFF;
        #1;
        check("R8 irq gating", err_irq, err_flags & m_eei);
        check("R9 any set", {63'd0, err_irq_any}, 64'd1);
        err_flags = ~m_eei;
        #1;
        check("R8 disabled channels", err_irq, 64'd0);
        check("R9 any clear", {63'd0, err_irq_any}, 64'd0);
        err_flags = 64'd1 << 40;
        #1;
        check("R8 ch40", err_irq, m_eei[40] ? (64'd1 << 40) : 64'd0);

        // R11 existing bits kept by another command
        do_write(8'h18, 32'h0000_0001, 4'b0001);
        check("R11 bits kept", req_enable, m_req);

        // R3 global set with don't-care low bits
        do_write(8'h18, 32'h8080_807B, 4'b0001);
        check("R3 global set", req_enable, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(8'h08, 32'hFFFF_FFFF, "R3 R10 global read hi");
        do_read(8'h0C, 32'hFFFF_FFFF, "R3 R10 global read lo");

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule